// File: doc/BRIEF.md
# Two-wire bus configuration register and condition monitor

This block holds the one-byte configuration for a two-wire serial bus controller and watches the bus lines for start and stop conditions. Software writes the byte through a simple write port. The enables, the pin-pair choice and a clock divider value are then presented as plain control outputs to the byte engines that sit beside this block. The raw clock and data lines pass through a two-flop synchroniser. A start is data falling while clock stays high; a stop is data rising while clock stays high.

The monitor counts clock rising edges since the last start, modulo 9. A start or stop that arrives while the bus is busy and that counter is between 2 and 8 inclusive is misplaced, and counts as a bus error. On a bus error during a master transfer, the block sends a one-cycle abort to the master engine, which releases the bus and goes idle. No stop interrupt is then raised for that transfer. On any bus error with the slave enabled, the block sends a one-cycle resynchronise pulse to the slave engine. Two sticky interrupt sources, one for stop and one for bus error, are combined into one interrupt line and are cleared by writing ones.

Top module: `i2c_cfg_monitor`

## Requirements
- R1: After reset, the register reads 0x00, every enable output is 0, `rate_div` holds the 100 kHz value, and `irq_src` and `irq` are 0.
- R2: A write stores bits 5:0 as written: bit 5 bus-error interrupt enable, bit 4 stop interrupt enable, bits 3:2 rate code, bit 1 master enable, bit 0 slave enable. Bit 7 always reads 0.
- R3: Bit 6, the pin-pair select, takes the written value only if master enable and slave enable were both 0 before the write. This holds even when the same write sets an enable. Otherwise bit 6 keeps its old value.
- R4: `rate_div` is the clock half-period in `clk` cycles, CLK_HZ/(2*rate). Rate code 00 gives 100 kHz, 01 gives 400 kHz and 10 gives 50 kHz. The reserved code 11 gives the 100 kHz value, although the register still reads 11.
- R5: A start or stop is misplaced when the bus is busy (a start was seen since the last stop) and the count of clock rising edges since the last start, modulo 9, is between 2 and 8.
- R6: A misplaced condition with master enable = 1 and `mst_xfer_busy` = 1 gives exactly one one-cycle `mst_abort` pulse.
- R7: A misplaced condition with slave enable = 1 gives exactly one one-cycle `slv_resync` pulse.
- R8: `irq_src[1]` (bus error) is set by a misplaced condition only when bit 5 = 1, master enable = 1 and `mst_xfer_busy` = 1.
- R9: `irq_src[0]` (stop) is set by a stop condition when bit 4 = 1 and either enable is 1.
- R10: After an abort, no stop flag is raised, neither for the aborting stop nor for any stop up to the next properly placed start.
- R11: `irq` is the OR of `irq_src`. A 1 in `irq_clr[i]` clears `irq_src[i]`, a 0 leaves it unchanged, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Register write byte |
| cfg_rd_data | output | 8 | Current register value |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| mst_xfer_busy | input | 1 | Master engine has a transfer in progress |
| mst_en | output | 1 | Master enable |
| slv_en | output | 1 | Slave enable |
| pin_alt | output | 1 | Alternate pin-pair select |
| rate_div | output | DIV_W | Clock half-period in clk cycles |
| mst_abort | output | 1 | Pulse: master must release the bus and go idle |
| slv_resync | output | 1 | Pulse: slave must reset and resynchronise |
| irq_clr | input | 2 | Write-one-to-clear for irq_src |
| irq_src | output | 2 | Sticky flags: bit 1 bus error, bit 0 stop |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `mst_xfer_busy` and the write port are synchronous to `clk`. They also assume that the bus lines change one at a time and stay put for several cycles, so that two conditions never reach the monitor back to back. The stimulus drives every bus phase for four clock cycles and never moves clock and data together. It holds `mst_xfer_busy` constant across each transaction and drives all inputs on the falling clock edge. The random part breaks transactions off after a random number of bits, with a random register value and transfer flag. It then compares the abort and resynchronise pulse counts and the flags against bench functions.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int SLOT_COUNT = 9;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);

  typedef enum logic [1:0] {
    RATE_STD  = 2'b00,
    RATE_FAST = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  typedef struct packed {
    logic  rsvd;
    logic  pin_alt;
    logic  berr_ie;
    logic  stop_ie;
    rate_e rate;
    logic  mst_en;
    logic  slv_en;
  } cfg_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic misplaced;
  } bus_evt_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det
  import i2cm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic              scl_d, sda_d;
  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic              start_c, stop_c, rise_c;

  // conditions need the clock high on both sides of the data edge
  assign start_c = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c  = scl_s & scl_d & ~sda_d & sda_s;
  assign rise_c  = scl_s & ~scl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      busy_q <= 1'b0;
      slot_q <= '0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (start_c)     busy_q <= 1'b1;
      else if (stop_c) busy_q <= 1'b0;
      if (start_c || stop_c)
        slot_q <= '0;
      else if (rise_c)
        slot_q <= (slot_q == SLOT_W'(SLOT_COUNT - 1)) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  assign evt.start     = start_c;
  assign evt.stop      = stop_c;
  assign evt.misplaced = (start_c | stop_c) & busy_q & (slot_q >= SLOT_W'(2));
endmodule

// File: rtl/i2cm_cfg_reg.sv
module i2cm_cfg_reg
  import i2cm_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int STD_HZ  = 100_000,
  parameter int FAST_HZ = 400_000,
  parameter int SLOW_HZ = 50_000,
  parameter int DIV_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output cfg_t             cfg,
  output logic [DIV_W-1:0] div
);
  localparam logic [DIV_W-1:0] DIV_STD  = DIV_W'(CLK_HZ / (2 * STD_HZ));
  localparam logic [DIV_W-1:0] DIV_FAST = DIV_W'(CLK_HZ / (2 * FAST_HZ));
  localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(CLK_HZ / (2 * SLOW_HZ));

  cfg_t cfg_q, cfg_nxt;

  always_comb begin
    cfg_nxt      = cfg_t'(wr_data);
    cfg_nxt.rsvd = 1'b0;
    // pin pair is frozen once either engine is running
    if (cfg_q.mst_en || cfg_q.slv_en) cfg_nxt.pin_alt = cfg_q.pin_alt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_nxt;
  end

  always_comb begin
    unique case (cfg_q.rate)
      RATE_FAST: div = DIV_FAST;
      RATE_SLOW: div = DIV_SLOW;
      default:   div = DIV_STD;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/i2cm_event.sv
module i2cm_event
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cfg_t       cfg,
  input  logic       mst_busy,
  input  bus_evt_t   evt,
  input  logic [1:0] clr,
  output logic       abort_p,
  output logic       resync_p,
  output logic [1:0] src
);
  localparam int SRC_STOP = 0;
  localparam int SRC_BERR = 1;

  logic       master_op, abort_c, quiet_q;
  logic [1:0] set_c, src_q;

  assign master_op = cfg.mst_en & mst_busy;
  assign abort_c   = evt.misplaced & master_op;

  assign set_c[SRC_BERR] = abort_c & cfg.berr_ie;
  assign set_c[SRC_STOP] = evt.stop & cfg.stop_ie & (cfg.mst_en | cfg.slv_en)
                         & ~abort_c & ~quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_p  <= 1'b0;
      resync_p <= 1'b0;
      quiet_q  <= 1'b0;
    end else begin
      abort_p  <= abort_c;
      resync_p <= evt.misplaced & cfg.slv_en;
      if (abort_c)        quiet_q <= 1'b1;
      else if (evt.start) quiet_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        src_q[i] <= 1'b0;
      else if (set_c[i]) src_q[i] <= 1'b1;
      else if (clr[i])   src_q[i] <= 1'b0;
    end
  end

  assign src = src_q;
endmodule

// File: rtl/i2c_cfg_monitor.sv
module i2c_cfg_monitor
  import i2cm_pkg::*;
#(
  parameter int CLK_HZ = 125_000_000,
  parameter int DIV_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [7:0]       cfg_wr_data,
  output logic [7:0]       cfg_rd_data,
  input  logic             scl_raw,
  input  logic             sda_raw,
  input  logic             mst_xfer_busy,
  output logic             mst_en,
  output logic             slv_en,
  output logic             pin_alt,
  output logic [DIV_W-1:0] rate_div,
  output logic             mst_abort,
  output logic             slv_resync,
  input  logic [1:0]       irq_clr,
  output logic [1:0]       irq_src,
  output logic             irq
);
  cfg_t       cfg;
  bus_evt_t   evt;
  logic [1:0] line_s;

  i2cm_cfg_reg #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg(cfg), .div(rate_div)
  );

  i2cm_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({scl_raw, sda_raw}), .q_out(line_s)
  );

  i2cm_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]), .evt(evt)
  );

  i2cm_event u_evt (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .mst_busy(mst_xfer_busy), .evt(evt),
    .clr(irq_clr), .abort_p(mst_abort), .resync_p(slv_resync), .src(irq_src)
  );

  assign cfg_rd_data = cfg;
  assign mst_en      = cfg.mst_en;
  assign slv_en      = cfg.slv_en;
  assign pin_alt     = cfg.pin_alt;
  assign irq         = |irq_src;
endmodule

// File: rtl/i2cm_monitor_chk.sv
module i2cm_monitor_chk #(
  parameter int CLK_HZ = 125_000_000,
  parameter int DIV_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [7:0]       cfg_rd_data,
  input logic             mst_xfer_busy,
  input logic             mst_en,
  input logic             slv_en,
  input logic             pin_alt,
  input logic [DIV_W-1:0] rate_div,
  input logic             mst_abort,
  input logic             slv_resync,
  input logic [1:0]       irq_src
);
  localparam logic [DIV_W-1:0] D_STD  = DIV_W'(CLK_HZ / 200_000);
  localparam logic [DIV_W-1:0] D_FAST = DIV_W'(CLK_HZ / 800_000);
  localparam logic [DIV_W-1:0] D_SLOW = DIV_W'(CLK_HZ / 100_000);

  a_r2_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_data[7]);

  a_r3_pin_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && (mst_en || slv_en)) |=> $stable(pin_alt));

  a_r4_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rate_div == D_STD || rate_div == D_FAST || rate_div == D_SLOW);

  a_r6_abort_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    mst_abort |-> $past(mst_en && mst_xfer_busy));

  a_r6_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    mst_abort |=> !mst_abort);

  a_r7_resync_needs_slave: assert property (@(posedge clk) disable iff (!rst_n)
    slv_resync |-> $past(slv_en));

  a_r8_berr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_src[1]) |-> $past(cfg_rd_data[5]));
endmodule

bind i2c_cfg_monitor i2cm_monitor_chk #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .mst_xfer_busy(mst_xfer_busy), .mst_en(mst_en), .slv_en(slv_en),
  .pin_alt(pin_alt), .rate_div(rate_div), .mst_abort(mst_abort),
  .slv_resync(slv_resync), .irq_src(irq_src)
);

// File: tb/i2c_cfg_monitor_test.sv
`timescale 1ns/1ps
module i2c_cfg_monitor_test;
  localparam int CLK_HZ = 125_000_000;
  localparam int DIV_W  = 16;
  localparam int Q      = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, scl_raw = 1, sda_raw = 1, mst_xfer_busy = 0;
  logic [7:0] cfg_wr_data = 0, cfg_rd_data;
  logic mst_en, slv_en, pin_alt, mst_abort, slv_resync, irq;
  logic [DIV_W-1:0] rate_div;
  logic [1:0] irq_clr = 0, irq_src;

  int n_chk = 0, n_bad = 0, n_abort = 0, n_resync = 0;
  logic [7:0] shadow = 0;

  always #4 clk = ~clk;

  i2c_cfg_monitor #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) uut (.*);

  always @(negedge clk) begin
    if (mst_abort)  n_abort++;
    if (slv_resync) n_resync++;
  end

  function automatic logic [7:0] f_next(logic [7:0] cur, logic [7:0] w);
    logic [7:0] n = w;
    n[7] = 1'b0;
    if (cur[1] | cur[0]) n[6] = cur[6];
    return n;
  endfunction

  function automatic int f_div(logic [1:0] r);
    case (r)
      2'b01:   return CLK_HZ / 800_000;
      2'b10:   return CLK_HZ / 100_000;
      default: return CLK_HZ / 200_000;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); cfg_wr_en = 1; cfg_wr_data = v;
    @(negedge clk); cfg_wr_en = 0;
    shadow = f_next(shadow, v);
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask
  task automatic b_start(); sda_raw = 1; scl_raw = 1; hold(); sda_raw = 0; hold(); scl_raw = 0; hold(); endtask
  task automatic b_bit(logic b); sda_raw = b; hold(); scl_raw = 1; hold(); scl_raw = 0; hold(); endtask
  task automatic b_stop(); sda_raw = 0; hold(); scl_raw = 1; hold(); sda_raw = 1; hold(); hold(); endtask
  task automatic b_rep(); sda_raw = 1; hold(); scl_raw = 1; hold(); sda_raw = 0; hold(); scl_raw = 0; hold(); endtask

  task automatic clear_all();
    @(negedge clk); irq_clr = 2'b11; @(negedge clk); irq_clr = 2'b00;
    n_abort = 0; n_resync = 0;
  endtask

  // k bits after a start, then a stop or a repeated start followed by a stop
  task automatic txn(int k, bit rep, bit busy, string tag);
    bit err, en, ab;
    int exp_src;
    mst_xfer_busy = busy;
    clear_all();
    b_start();
    for (int i = 0; i < k; i++) b_bit(1'($urandom_range(0, 1)));
    if (rep) begin b_rep(); b_stop(); end
    else b_stop();
    err = ((k + 1) % 9) >= 2;
    en  = shadow[1] | shadow[0];
    ab  = err & shadow[1] & busy;
    exp_src = {ab & shadow[5], shadow[4] & en & ~ab};
    chk({tag, " R5 R6 abort count"}, n_abort, int'(ab));
    chk({tag, " R7 resync count"}, n_resync, int'(err & shadow[0]));
    chk({tag, " R8 R9 R10 irq_src"}, int'(irq_src), exp_src);
    chk({tag, " R11 irq"}, int'(irq), int'(exp_src != 0));
    mst_xfer_busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", int'(cfg_rd_data), 0);
    chk("R1 div", int'(rate_div), f_div(2'b00));
    chk("R1 enables", int'({mst_en, slv_en, pin_alt}), 0);
    chk("R1 irq", int'({irq_src, irq}), 0);
    // R2 R3 R4: enable and pin set together, reserved rate
    wr(8'hFF);
    chk("R2 write ff", int'(cfg_rd_data), 8'h7F);
    chk("R3 pin with enable", int'(pin_alt), 1);
    chk("R4 reserved rate", int'(rate_div), f_div(2'b00));
    wr(8'h00);
    chk("R3 pin locked", int'(cfg_rd_data), 8'h40);
    wr(8'h04);
    chk("R3 pin free", int'(pin_alt), 0);
    chk("R4 fast", int'(rate_div), f_div(2'b01));
    wr(8'h08);
    chk("R4 slow", int'(rate_div), f_div(2'b10));
    // R11 write-one-to-clear on stop flag
    wr(8'h11);
    txn(8, 0, 0, "dir stop");
    b_start(); b_stop();
    @(negedge clk); irq_clr = 2'b10; @(negedge clk); irq_clr = 2'b00;
    chk("R11 wrong clear keeps", int'(irq_src), 1);
    @(negedge clk); irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00;
    chk("R11 clear", int'({irq_src, irq}), 0);
    // R10 misplaced repeated start aborts, later stop silent
    wr(8'h33);
    txn(3, 1, 1, "dir quiet");
    // R5 idle-safe slots and boundaries
    txn(0, 0, 1, "dir k0");
    txn(1, 0, 1, "dir k1");
    txn(7, 0, 1, "dir k7");
    txn(9, 1, 1, "dir k9");
    // random
    for (int t = 0; t < 40; t++) begin
      wr(8'($urandom));
      txn($urandom_range(0, 18), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "rnd");
      chk("R2 R3 rnd cfg", int'(cfg_rd_data), int'(shadow));
      chk("R4 rnd div", int'(rate_div), f_div(shadow[3:2]));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule